// File: doc/BRIEF.md
# Eviction-Tracking Miss Predictor

This block sits beside a multi-level cache hierarchy and tells the cache controller which levels beyond the first can safely be skipped for a given block address. It keeps a small set-associative table indexed by block address. Every entry carries one "known absent" flag per level beyond L1. When a level reports that it has evicted a block, the flag for that level is set in the block's entry. When a level reports that it has filled the block again, that flag is cleared. A query returns the flags of the matching entry as a miss vector. A set bit means the controller may bypass that level.

The answer is conservative. A level is never flagged while the block lives there. An address with no entry, or whose entry was displaced, answers all zeros, which means "may hit" everywhere. Eviction and fill reports that arrive in the same cycle as a query are applied before the query is answered. The answer appears one cycle after the query.

Levels are numbered 0 to LEVELS-1, with 0 being L1. The miss vector bit k-1 belongs to level k. A block address is split into a set index (its low SET_W bits) and a tag (the remaining high bits). The update order inside one cycle is fixed: eviction first, then fill, then the query lookup.

Top module: `rtrk_miss_pred`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) drives q_ack and q_miss to zero and empties the table. Until an eviction with a level from 1 to LEVELS-1 arrives, every query answers all zeros.
- R2: q_ack is high exactly in the cycle after a cycle with q_en high. In a cycle that follows one with q_en low, q_miss is all zeros.
- R3: An eviction report (ev_en, ev_blk, ev_lvl = k with 1 <= k <= LEVELS-1) sets bit k-1 of the entry for ev_blk. A later query of ev_blk returns that bit set.
- R4: The flags of the different levels are independent. An eviction from one level changes no other level's bit for that block.
- R5: A fill report (pl_en, pl_blk, pl_lvl = k) clears bit k-1 of a matching entry and leaves its other bits unchanged.
- R6: An entry whose bits all become zero is freed. The next eviction that misses in that set reuses the freed way instead of displacing a live entry.
- R7: Each set holds WAYS entries. An eviction report for a new address in a full set replaces the entry whose last eviction report is oldest, and queries of the displaced address then answer zeros. An eviction report that hits an existing entry makes that entry the most recent.
- R8: An eviction or fill report made in the same cycle as a query of the same address is reflected in that query's answer.
- R9: If an eviction and a fill for the same address and the same level arrive in one cycle, the fill wins and the level's bit ends up clear.
- R10: Reports with level 0 (L1) leave the table unchanged.
- R11: A query of an address with no entry returns all zeros, even when another tag occupies the same set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_en | input | 1 | Eviction report valid |
| ev_blk | input | BLK_W (16) | Block address evicted |
| ev_lvl | input | LVL_W (2) | Level that evicted the block |
| pl_en | input | 1 | Fill report valid |
| pl_blk | input | BLK_W (16) | Block address filled |
| pl_lvl | input | LVL_W (2) | Level that received the block |
| q_en | input | 1 | Query valid |
| q_blk | input | BLK_W (16) | Block address queried |
| q_ack | output | 1 | Query answer valid, one cycle after q_en |
| q_miss | output | LEVELS-1 (3) | Definite-miss vector; bit k-1 is for level k |

## Verification
A corrupted entry becomes visible the first time its address is queried. The miss vector then shows either a set bit for a level that has since been filled, which is the unsafe case, or a missing bit after an eviction. Because the answer is registered once, this shows up in the cycle right after that query. A wrong recency order stays hidden until a set overflows. It then surfaces as the wrong address losing its flags. The bench therefore drives contention on a few sets with more tags than ways and compares every answer against a timestamp-based replacement model.

// File: rtl/rtrk_pkg.sv
package rtrk_pkg;
    localparam int BLK_W  = 16;
    localparam int LEVELS = 4;
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int PAY_W  = LEVELS - 1;
    localparam int SET_W  = 3;
    localparam int SETS   = 1 << SET_W;
    localparam int WAYS   = 4;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = BLK_W - SET_W;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [PAY_W-1:0]  absent;
        logic [WAY_W-1:0]  age;
    } slot_t;

    typedef slot_t [WAYS-1:0] row_t;

    // one-hot flag for levels 1..LEVELS-1, zero for level 0
    function automatic logic [PAY_W-1:0] lvl_mask(input logic [LVL_W-1:0] lvl);
        logic [PAY_W-1:0] m;
        m = '0;
        for (int k = 1; k < LEVELS; k++)
            if (lvl == LVL_W'(k)) m[k-1] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/rtrk_match.sv
module rtrk_match
    import rtrk_pkg::*;
(
    input  row_t             row_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             any_o,
    output logic [WAY_W-1:0] idx_o
);
    logic [WAYS-1:0] hit;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign hit[w] = row_i[w].vld && (row_i[w].tag == tag_i);
        end
    endgenerate

    always_comb begin
        any_o = |hit;
        idx_o = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (hit[w]) idx_o = WAY_W'(w);
    end
endmodule

// File: rtl/rtrk_evict_row.sv
module rtrk_evict_row
    import rtrk_pkg::*;
(
    input  logic             en_i,
    input  row_t             row_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic [PAY_W-1:0] mask_i,
    output row_t             row_o
);
    logic             any;
    logic [WAY_W-1:0] hidx;
    logic [WAY_W-1:0] vidx;
    logic [WAY_W-1:0] tgt;
    logic             found;

    rtrk_match u_m (
        .row_i (row_i),
        .tag_i (tag_i),
        .any_o (any),
        .idx_o (hidx)
    );

    // victim: lowest free way, otherwise the oldest way
    always_comb begin
        vidx  = '0;
        found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!row_i[w].vld && !found) begin
                vidx  = WAY_W'(w);
                found = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++)
                if (row_i[w].age == WAY_W'(WAYS - 1)) vidx = WAY_W'(w);
        end
    end

    always_comb begin
        tgt   = any ? hidx : vidx;
        row_o = row_i;
        if (en_i && (|mask_i)) begin
            if (any) begin
                row_o[tgt].absent = row_i[tgt].absent | mask_i;
            end else begin
                row_o[tgt].vld    = 1'b1;
                row_o[tgt].tag    = tag_i;
                row_o[tgt].absent = mask_i;
            end
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == tgt)
                    row_o[w].age = '0;
                else if (row_i[w].age < row_i[tgt].age)
                    row_o[w].age = row_i[w].age + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtrk_place_row.sv
module rtrk_place_row
    import rtrk_pkg::*;
(
    input  logic             en_i,
    input  row_t             row_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic [PAY_W-1:0] mask_i,
    output row_t             row_o
);
    logic             any;
    logic [WAY_W-1:0] hidx;
    logic [PAY_W-1:0] left;

    rtrk_match u_m (
        .row_i (row_i),
        .tag_i (tag_i),
        .any_o (any),
        .idx_o (hidx)
    );

    always_comb begin
        row_o = row_i;
        left  = row_i[hidx].absent & ~mask_i;
        if (en_i && any && (|mask_i)) begin
            row_o[hidx].absent = left;
            if (left == '0) row_o[hidx].vld = 1'b0;
        end
    end
endmodule

// File: rtl/rtrk_miss_pred.sv
module rtrk_miss_pred
    import rtrk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_en,
    input  logic [BLK_W-1:0] ev_blk,
    input  logic [LVL_W-1:0] ev_lvl,
    input  logic             pl_en,
    input  logic [BLK_W-1:0] pl_blk,
    input  logic [LVL_W-1:0] pl_lvl,
    input  logic             q_en,
    input  logic [BLK_W-1:0] q_blk,
    output logic             q_ack,
    output logic [PAY_W-1:0] q_miss
);
    row_t tbl_q [SETS];
    row_t tbl_e [SETS];
    row_t tbl_p [SETS];
    row_t ev_row;
    row_t pl_row;

    logic [SET_W-1:0] ev_set, pl_set, q_set;
    logic [TAG_W-1:0] ev_tag, pl_tag, q_tag;
    logic             q_any;
    logic [WAY_W-1:0] q_idx;
    logic [PAY_W-1:0] q_bits;

    assign ev_set = ev_blk[SET_W-1:0];
    assign ev_tag = ev_blk[BLK_W-1:SET_W];
    assign pl_set = pl_blk[SET_W-1:0];
    assign pl_tag = pl_blk[BLK_W-1:SET_W];
    assign q_set  = q_blk[SET_W-1:0];
    assign q_tag  = q_blk[BLK_W-1:SET_W];

    // stage 1: eviction
    rtrk_evict_row u_ev (
        .en_i   (ev_en),
        .row_i  (tbl_q[ev_set]),
        .tag_i  (ev_tag),
        .mask_i (lvl_mask(ev_lvl)),
        .row_o  (ev_row)
    );

    always_comb begin
        tbl_e = tbl_q;
        if (ev_en) tbl_e[ev_set] = ev_row;
    end

    // stage 2: fill, applied after the eviction so a fill wins
    rtrk_place_row u_pl (
        .en_i   (pl_en),
        .row_i  (tbl_e[pl_set]),
        .tag_i  (pl_tag),
        .mask_i (lvl_mask(pl_lvl)),
        .row_o  (pl_row)
    );

    always_comb begin
        tbl_p = tbl_e;
        if (pl_en) tbl_p[pl_set] = pl_row;
    end

    // stage 3: query sees the fully updated table
    rtrk_match u_q (
        .row_i (tbl_p[q_set]),
        .tag_i (q_tag),
        .any_o (q_any),
        .idx_o (q_idx)
    );

    assign q_bits = q_any ? tbl_p[q_set][q_idx].absent : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tbl_q[s][w].vld    <= 1'b0;
                    tbl_q[s][w].tag    <= '0;
                    tbl_q[s][w].absent <= '0;
                    tbl_q[s][w].age    <= WAY_W'(w);
                end
            end
            q_ack  <= 1'b0;
            q_miss <= '0;
        end else begin
            tbl_q  <= tbl_p;
            q_ack  <= q_en;
            q_miss <= q_en ? q_bits : '0;
        end
    end
endmodule

// File: rtl/rtrk_chk.sv
module rtrk_chk
    import rtrk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ev_en,
    input logic [BLK_W-1:0] ev_blk,
    input logic [LVL_W-1:0] ev_lvl,
    input logic             pl_en,
    input logic [BLK_W-1:0] pl_blk,
    input logic [LVL_W-1:0] pl_lvl,
    input logic             q_en,
    input logic [BLK_W-1:0] q_blk,
    input logic             q_ack,
    input logic [PAY_W-1:0] q_miss
);
    logic [PAY_W-1:0] ev_m, pl_m;
    logic             seen_q;

    assign ev_m = lvl_mask(ev_lvl);
    assign pl_m = lvl_mask(pl_lvl);

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else if (ev_en && (|ev_m)) seen_q <= 1'b1;
    end

    // R1
    quiet_until_evict_chk: assert property (@(posedge clk) disable iff (rst)
        (!seen_q && !(ev_en && (|ev_m))) |=> (q_miss == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!q_ack && (q_miss == '0)));

    // R2
    ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
        q_en |=> q_ack);

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !q_en |=> (!q_ack && (q_miss == '0)));

    // R8
    evict_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (q_en && ev_en && (ev_blk == q_blk) && !(pl_en && (pl_blk == q_blk)))
        |=> ((q_miss & $past(ev_m)) == $past(ev_m)));

    // R9
    place_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (q_en && pl_en && (pl_blk == q_blk))
        |=> ((q_miss & $past(pl_m)) == '0));
endmodule

bind rtrk_miss_pred rtrk_chk u_chk (.*);

// File: tb/sim_rtrk_miss_pred.sv
`timescale 1ns/1ps
module sim_rtrk_miss_pred;
    import rtrk_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ev_en = 1'b0, pl_en = 1'b0, q_en = 1'b0;
    logic [BLK_W-1:0] ev_blk = '0, pl_blk = '0, q_blk = '0;
    logic [LVL_W-1:0] ev_lvl = '0, pl_lvl = '0;
    logic             q_ack;
    logic [PAY_W-1:0] q_miss;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtrk_miss_pred u0 (
        .clk(clk), .rst(rst),
        .ev_en(ev_en), .ev_blk(ev_blk), .ev_lvl(ev_lvl),
        .pl_en(pl_en), .pl_blk(pl_blk), .pl_lvl(pl_lvl),
        .q_en(q_en), .q_blk(q_blk),
        .q_ack(q_ack), .q_miss(q_miss)
    );

    // reference model: recency kept as timestamps of eviction reports
    logic             m_vld  [SETS][WAYS];
    logic [TAG_W-1:0] m_tag  [SETS][WAYS];
    logic [PAY_W-1:0] m_bits [SETS][WAYS];
    int unsigned      m_ts   [SETS][WAYS];
    int unsigned      m_now;

    function automatic void m_clear();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_vld[s][w] = 1'b0; m_tag[s][w] = '0;
                m_bits[s][w] = '0;  m_ts[s][w] = 0;
            end
        m_now = 0;
    endfunction

    function automatic int m_find(input logic [BLK_W-1:0] b);
        int s;
        s = int'(b[SET_W-1:0]);
        for (int w = 0; w < WAYS; w++)
            if (m_vld[s][w] && m_tag[s][w] == b[BLK_W-1:SET_W]) return w;
        return -1;
    endfunction

    function automatic void m_evict(input logic [BLK_W-1:0] b, input int lvl);
        int s, w;
        if (lvl < 1 || lvl >= LEVELS) return;
        s = int'(b[SET_W-1:0]);
        w = m_find(b);
        if (w < 0) begin
            for (int j = WAYS - 1; j >= 0; j--) if (!m_vld[s][j]) w = j;
            if (w < 0) begin
                w = 0;
                for (int j = 1; j < WAYS; j++) if (m_ts[s][j] < m_ts[s][w]) w = j;
            end
            m_vld[s][w] = 1'b1;
            m_tag[s][w] = b[BLK_W-1:SET_W];
            m_bits[s][w] = '0;
        end
        m_bits[s][w][lvl-1] = 1'b1;
        m_now++;
        m_ts[s][w] = m_now;
    endfunction

    function automatic void m_place(input logic [BLK_W-1:0] b, input int lvl);
        int s, w;
        if (lvl < 1 || lvl >= LEVELS) return;
        s = int'(b[SET_W-1:0]);
        w = m_find(b);
        if (w < 0) return;
        m_bits[s][w][lvl-1] = 1'b0;
        if (m_bits[s][w] == '0) m_vld[s][w] = 1'b0;
    endfunction

    function automatic logic [PAY_W-1:0] m_query(input logic [BLK_W-1:0] b);
        int w;
        w = m_find(b);
        if (w < 0) return '0;
        return m_bits[int'(b[SET_W-1:0])][w];
    endfunction

    function automatic logic [BLK_W-1:0] mk(input int tag, input int set);
        return {TAG_W'(tag), SET_W'(set)};
    endfunction

    // one cycle: drive at negedge, update model, check at the next negedge
    task automatic step(input bit e, input logic [BLK_W-1:0] eb, input int el,
                        input bit p, input logic [BLK_W-1:0] pb, input int pl,
                        input bit q, input logic [BLK_W-1:0] qb, input string tag);
        logic [PAY_W-1:0] exp;
        ev_en = e; ev_blk = eb; ev_lvl = LVL_W'(el);
        pl_en = p; pl_blk = pb; pl_lvl = LVL_W'(pl);
        q_en  = q; q_blk  = qb;
        if (e) m_evict(eb, el);
        if (p) m_place(pb, pl);
        exp = q ? m_query(qb) : '0;
        @(negedge clk);
        n_chk++;
        if (q_ack !== q || q_miss !== exp) begin
            n_fail++;
            $display("FAIL %s: q_ack=%0b q_miss=%b expected q_ack=%0b q_miss=%b",
                     tag, q_ack, q_miss, q, exp);
        end
    endtask

    task automatic ev1(input logic [BLK_W-1:0] b, input int l, input string tag);
        step(1, b, l, 0, '0, 0, 0, '0, tag);
    endtask
    task automatic pl1(input logic [BLK_W-1:0] b, input int l, input string tag);
        step(0, '0, 0, 1, b, l, 0, '0, tag);
    endtask
    task automatic qy(input logic [BLK_W-1:0] b, input string tag);
        step(0, '0, 0, 0, '0, 0, 1, b, tag);
    endtask

    initial begin
        m_clear();
        void'($urandom(32'h5EED_0042));
        // R1: reset with a query pending
        q_en = 1'b1; q_blk = mk(1, 0);
        ev_en = 1'b1; ev_blk = mk(1, 0); ev_lvl = 2'd1;
        repeat (3) @(negedge clk);
        n_chk++;
        if (q_ack !== 1'b0 || q_miss !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: q_ack=%0b q_miss=%b expected 0 000", q_ack, q_miss);
        end
        rst = 1'b0;
        step(0, '0, 0, 0, '0, 0, 1, mk(1, 0), "R1 first query");
        step(0, '0, 0, 0, '0, 0, 0, '0, "R2 idle");
        // R3, R4, R11: independent level flags
        ev1(mk(9, 2), 2, "R3 evict L2");
        qy(mk(9, 2), "R3 query 010");
        ev1(mk(9, 2), 3, "R4 evict L3");
        qy(mk(9, 2), "R4 query 110");
        qy(mk(10, 2), "R11 other tag same set");
        // R5
        pl1(mk(9, 2), 2, "R5 fill L2");
        qy(mk(9, 2), "R5 query 100");
        // R10: level 0 ignored
        ev1(mk(9, 2), 0, "R10 evict L1");
        pl1(mk(9, 2), 0, "R10 fill L1");
        qy(mk(9, 2), "R10 query 100");
        // R6: freed way reused, oldest entry kept
        for (int t = 1; t <= 4; t++) ev1(mk(t, 5), 1, "R6 fill set");
        pl1(mk(4, 5), 1, "R6 free way");
        ev1(mk(5, 5), 1, "R6 new entry");
        qy(mk(1, 5), "R6 oldest survives");
        qy(mk(5, 5), "R6 new entry 001");
        qy(mk(4, 5), "R6 freed entry zero");
        // R7: refresh then overflow
        for (int t = 1; t <= 4; t++) ev1(mk(t, 6), 1, "R7 fill set");
        ev1(mk(1, 6), 2, "R7 refresh");
        ev1(mk(5, 6), 1, "R7 overflow");
        qy(mk(2, 6), "R7 displaced zero");
        qy(mk(1, 6), "R7 refreshed 011");
        qy(mk(5, 6), "R7 new 001");
        // R8: same-cycle forwarding
        step(1, mk(3, 7), 1, 0, '0, 0, 1, mk(3, 7), "R8 evict+query");
        step(0, '0, 0, 1, mk(3, 7), 1, 1, mk(3, 7), "R8 fill+query");
        // R9: fill wins over eviction
        step(1, mk(4, 7), 2, 1, mk(4, 7), 2, 1, mk(4, 7), "R9 new address");
        ev1(mk(4, 7), 1, "R9 prime");
        step(1, mk(4, 7), 1, 1, mk(4, 7), 1, 1, mk(4, 7), "R9 existing");
        // random contention on two sets, R3/R5/R7
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 3) != 0, mk($urandom % 6, $urandom % 2), $urandom % 4,
                 ($urandom % 3) == 0, mk($urandom % 6, $urandom % 2), $urandom % 4,
                 ($urandom % 5) != 0, mk($urandom % 6, $urandom % 2),
                 "R3/R5/R7 random");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule